// File: doc/BRIEF.md
# Storage Exception Entry Encoder

This block performs the single state update that moves a processor into an exception handler. A requester presents an exception kind, a small cause code, the current machine state word, the address of the next instruction and, for data-side faults, the faulting effective address. In the clock edge where the request is consumed, the block registers a return address, a saved machine state word, a data-fault status word, a data fault address, the rewritten machine state and the handler vector address.

The block decides whether a request is consumed, taken or held. External and decrementer requests stay pending while the external-enable bit is clear. Machine checks stay pending while the machine-check enable bit is clear. A floating-point program exception with both FP exception-mode bits clear is consumed and then dropped. The requester holds `excValid` until it sees `excAccept` high.

Top module: `excEntry`

## Requirements
- R1: After reset, every registered output is zero and `entryValid` is low.
- R2: For a data storage fault (kind 2), `dataStatus` is rebuilt from zero. Cause bits [1:0] select the base value: 0 gives 0x40000000 (translation miss), 1 gives 0x08000000 (protection), 2 gives 0x80000000 (unsupported), and 3 gives 0x84000000 (unsupported direct-store). Cause bit 2 (store) adds 0x02000000.
- R3: For an instruction storage fault (kind 3), `savedMsr` is the current state with bits 31:16 cleared. Cause [1:0] then adds a value: 0 adds 0x40000000, 1 adds 0x08000000, and 2 (no-execute) or 3 (guarded or direct-store) add 0x10000000.
- R4: For a program exception (kind 6), `savedMsr` has bits 31:16 cleared and always has 0x00010000 set. Cause [1:0] adds a value: 0 (FP enabled) adds 0x00100000, 1 (illegal) adds 0x00080000, 2 (privileged) adds 0x00040000, and 3 (trap) adds 0x00020000. For every other taken kind except 2 and 3, `savedMsr` equals the current state.
- R5: Alignment (5), program (6) and FP-unavailable (7) exceptions set `retAddr` to `nextPc` minus 4. All other taken kinds set it to `nextPc`.
- R6: On entry, `newMsr` is the current state with these bits cleared: 18 (power), 15 (external enable), 14 (problem), 13 (FP available), 11 and 8 (FP modes), 10 (single step), 9 (branch trace), 5 and 4 (translation) and 1 (recoverable). Bit 0 (little-endian) is loaded from bit 16. Bits 12 (machine-check enable), 16 and 6 (prefix) keep their values.
- R7: `vectorAddr` is the exception number shifted left by 8. The numbers are: reset 1, machine check 2, data 3, instruction 4, external 5, alignment 6, program 7, FP-unavailable 8, decrementer 9, system call 0xC and trace 0xD. A reset with bit 6 set adds 0xFFC00 to the number.
- R8: External (4) and decrementer (8) requests are not accepted while bit 15 is clear, and no output changes.
- R9: A program request with cause 0 and bits 11 and 8 both clear is accepted but leaves every registered output unchanged, with no `entryValid`. The reserved kinds 11 to 15 are handled the same way.
- R10: A machine check (kind 1) is not accepted while bit 12 is clear. When it is taken, bit 12 of `newMsr` is cleared.
- R11: `excAccept` is combinational in the cycle of a consumable request. The outputs load on that clock edge, and `entryValid` is high for exactly the following cycle. Without a take, the outputs hold their values.
- R12: `dataFaultAddr` loads `faultAddr` only for data storage (2) and alignment (5) entries. `dataStatus` loads only for data storage entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception request present |
| excType | input | 4 | Exception kind code |
| excCause | input | 3 | Cause code, meaning depends on kind |
| curMsr | input | 32 | Current machine state word |
| nextPc | input | 32 | Address of the next instruction |
| faultAddr | input | 32 | Faulting effective address |
| excAccept | output | 1 | Request consumed this cycle |
| entryValid | output | 1 | One-cycle pulse after a taken entry |
| retAddr | output | 32 | Saved return address |
| savedMsr | output | 32 | Saved machine state |
| dataStatus | output | 32 | Data fault status word |
| dataFaultAddr | output | 32 | Data fault address |
| newMsr | output | 32 | Machine state for the handler |
| vectorAddr | output | 32 | Handler entry address |

## Verification
The hardest case to reach from the ports is a gated request that arrives while earlier entries already hold non-zero outputs. The bench has to show that a deferred external request, a blocked machine check or a discarded FP program exception leaves every register exactly as it was. The stimulus therefore interleaves random taken entries with gated requests, so the outputs always hold distinctive values that any stray write would change. Directed cases add the reset with the prefix bit, a store to a direct-store area, and back-to-back machine checks with the enable bit toggled.

// File: rtl/excEntryPkg.sv
package excEntryPkg;
  localparam int XLEN    = 32;
  localparam int KIND_W  = 4;
  localparam int CAUSE_W = 3;
  localparam int VEC_SH  = 8;
  localparam int NUM_W   = XLEN - VEC_SH;

  localparam int B_LE  = 0;
  localparam int B_RI  = 1;
  localparam int B_DR  = 4;
  localparam int B_IR  = 5;
  localparam int B_IP  = 6;
  localparam int B_FE1 = 8;
  localparam int B_BE  = 9;
  localparam int B_SE  = 10;
  localparam int B_FE0 = 11;
  localparam int B_ME  = 12;
  localparam int B_FP  = 13;
  localparam int B_PR  = 14;
  localparam int B_EE  = 15;
  localparam int B_ILE = 16;
  localparam int B_POW = 18;

  localparam logic [NUM_W-1:0] RESET_PREFIX = 24'h0FFC00;

  typedef enum logic [KIND_W-1:0] {
    K_RESET = 4'd0, K_MCHK = 4'd1, K_DATA = 4'd2, K_INST = 4'd3,
    K_EXT = 4'd4, K_ALIGN = 4'd5, K_PROG = 4'd6, K_FPUN = 4'd7,
    K_DECR = 4'd8, K_SYSC = 4'd9, K_TRACE = 4'd10
  } excKind_e;

  typedef struct packed {
    logic take;
    logic loadStatus;
    logic loadAddr;
    logic useCurrent;
    logic clearHigh;
    logic clearMe;
    logic prefixAdd;
  } excStrobe_t;
endpackage

// File: rtl/excEntryCtrl.sv
module excEntryCtrl
  import excEntryPkg::*;
(
  input  logic               excValid,
  input  logic [KIND_W-1:0]  excType,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    curMsr,
  output logic               excAccept,
  output excStrobe_t         strobe
);
  logic held;
  logic dropped;
  logic known;

  always_comb begin
    known   = (excType <= KIND_W'(K_TRACE));
    held    = 1'b0;
    dropped = !known;
    case (excType)
      K_EXT, K_DECR: held = !curMsr[B_EE];
      K_MCHK:        held = !curMsr[B_ME];
      K_PROG:        dropped = (excCause[1:0] == 2'd0) &&
                               !curMsr[B_FE0] && !curMsr[B_FE1];
      default: ;
    endcase
  end

  assign excAccept = excValid && !held;

  always_comb begin
    strobe            = '0;
    strobe.take       = excAccept && !dropped;
    strobe.loadStatus = strobe.take && (excType == K_DATA);
    strobe.loadAddr   = strobe.take && (excType == K_DATA || excType == K_ALIGN);
    strobe.useCurrent = (excType == K_ALIGN || excType == K_PROG || excType == K_FPUN);
    strobe.clearHigh  = (excType == K_INST || excType == K_PROG || excType == K_DATA);
    strobe.clearMe    = (excType == K_MCHK);
    strobe.prefixAdd  = (excType == K_RESET) && curMsr[B_IP];
  end
endmodule

// File: rtl/excEntryDatapath.sv
module excEntryDatapath
  import excEntryPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  excStrobe_t         strobe,
  input  logic [KIND_W-1:0]  excType,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    curMsr,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [XLEN-1:0]    faultAddr,
  output logic               entryValid,
  output logic [XLEN-1:0]    retAddr,
  output logic [XLEN-1:0]    savedMsr,
  output logic [XLEN-1:0]    dataStatus,
  output logic [XLEN-1:0]    dataFaultAddr,
  output logic [XLEN-1:0]    newMsr,
  output logic [XLEN-1:0]    vectorAddr
);
  localparam int HALF = XLEN / 2;

  logic [NUM_W-1:0] excNum;
  logic [NUM_W-1:0] vecNum;
  logic [XLEN-1:0]  causeBits;
  logic [XLEN-1:0]  statusNext;
  logic [XLEN-1:0]  savedNext;
  logic [XLEN-1:0]  msrNext;
  logic [XLEN-1:0]  retNext;

  always_comb begin
    case (excType)
      K_RESET: excNum = NUM_W'(1);
      K_MCHK:  excNum = NUM_W'(2);
      K_DATA:  excNum = NUM_W'(3);
      K_INST:  excNum = NUM_W'(4);
      K_EXT:   excNum = NUM_W'(5);
      K_ALIGN: excNum = NUM_W'(6);
      K_PROG:  excNum = NUM_W'(7);
      K_FPUN:  excNum = NUM_W'(8);
      K_DECR:  excNum = NUM_W'(9);
      K_SYSC:  excNum = NUM_W'(12);
      K_TRACE: excNum = NUM_W'(13);
      default: excNum = '0;
    endcase
    vecNum = excNum + (strobe.prefixAdd ? RESET_PREFIX : '0);
  end

  always_comb begin
    statusNext = '0;
    case (excCause[1:0])
      2'd0: statusNext[30] = 1'b1;
      2'd1: statusNext[27] = 1'b1;
      2'd2: statusNext[31] = 1'b1;
      default: begin
        statusNext[31] = 1'b1;
        statusNext[26] = 1'b1;
      end
    endcase
    statusNext[25] = excCause[2];
  end

  always_comb begin
    causeBits = '0;
    if (excType == K_INST) begin
      case (excCause[1:0])
        2'd0:    causeBits[30] = 1'b1;
        2'd1:    causeBits[27] = 1'b1;
        default: causeBits[28] = 1'b1;
      endcase
    end else if (excType == K_PROG) begin
      causeBits[16] = 1'b1;
      case (excCause[1:0])
        2'd0:    causeBits[20] = 1'b1;
        2'd1:    causeBits[19] = 1'b1;
        2'd2:    causeBits[18] = 1'b1;
        default: causeBits[17] = 1'b1;
      endcase
    end
    savedNext = strobe.clearHigh ? ({{HALF{1'b0}}, curMsr[HALF-1:0]} | causeBits)
                                 : curMsr;
  end

  always_comb begin
    msrNext = curMsr;
    msrNext[B_POW] = 1'b0;
    msrNext[B_EE]  = 1'b0;
    msrNext[B_PR]  = 1'b0;
    msrNext[B_FP]  = 1'b0;
    msrNext[B_FE0] = 1'b0;
    msrNext[B_FE1] = 1'b0;
    msrNext[B_SE]  = 1'b0;
    msrNext[B_BE]  = 1'b0;
    msrNext[B_IR]  = 1'b0;
    msrNext[B_DR]  = 1'b0;
    msrNext[B_RI]  = 1'b0;
    msrNext[B_LE]  = curMsr[B_ILE];
    if (strobe.clearMe) msrNext[B_ME] = 1'b0;
    retNext = strobe.useCurrent ? (nextPc - XLEN'(4)) : nextPc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryValid    <= 1'b0;
      retAddr       <= '0;
      savedMsr      <= '0;
      dataStatus    <= '0;
      dataFaultAddr <= '0;
      newMsr        <= '0;
      vectorAddr    <= '0;
    end else begin
      entryValid <= strobe.take;
      if (strobe.take) begin
        retAddr    <= retNext;
        savedMsr   <= savedNext;
        newMsr     <= msrNext;
        vectorAddr <= {vecNum, {VEC_SH{1'b0}}};
      end
      if (strobe.loadStatus) dataStatus    <= statusNext;
      if (strobe.loadAddr)   dataFaultAddr <= faultAddr;
    end
  end
endmodule

// File: rtl/excEntry.sv
module excEntry
  import excEntryPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               excValid,
  input  logic [KIND_W-1:0]  excType,
  input  logic [CAUSE_W-1:0] excCause,
  input  logic [XLEN-1:0]    curMsr,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [XLEN-1:0]    faultAddr,
  output logic               excAccept,
  output logic               entryValid,
  output logic [XLEN-1:0]    retAddr,
  output logic [XLEN-1:0]    savedMsr,
  output logic [XLEN-1:0]    dataStatus,
  output logic [XLEN-1:0]    dataFaultAddr,
  output logic [XLEN-1:0]    newMsr,
  output logic [XLEN-1:0]    vectorAddr
);
  excStrobe_t strobe;

  excEntryCtrl u_ctrl (
    .excValid (excValid),
    .excType  (excType),
    .excCause (excCause),
    .curMsr   (curMsr),
    .excAccept(excAccept),
    .strobe   (strobe)
  );

  excEntryDatapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .excType      (excType),
    .excCause     (excCause),
    .curMsr       (curMsr),
    .nextPc       (nextPc),
    .faultAddr    (faultAddr),
    .entryValid   (entryValid),
    .retAddr      (retAddr),
    .savedMsr     (savedMsr),
    .dataStatus   (dataStatus),
    .dataFaultAddr(dataFaultAddr),
    .newMsr       (newMsr),
    .vectorAddr   (vectorAddr)
  );
endmodule

// File: rtl/excEntry_chk.sv
module excEntry_chk
  import excEntryPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               excValid,
  input logic [KIND_W-1:0]  excType,
  input logic [XLEN-1:0]    curMsr,
  input logic               excAccept,
  input logic               entryValid,
  input logic [XLEN-1:0]    retAddr,
  input logic [XLEN-1:0]    dataStatus,
  input logic [XLEN-1:0]    newMsr,
  input logic [XLEN-1:0]    vectorAddr
);
  assert_ext_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && (excType == K_EXT || excType == K_DECR) && !curMsr[B_EE]) |-> !excAccept);

  assert_mchk_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (excValid && excType == K_MCHK && !curMsr[B_ME]) |-> !excAccept);

  assert_mchk_clears_me_R10: assert property (@(posedge clk) disable iff (!rstN)
    (excAccept && excType == K_MCHK) |=> (entryValid && !newMsr[B_ME]));

  assert_entry_after_accept_R11: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> $past(excAccept));

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !entryValid |-> ($stable(retAddr) && $stable(newMsr) && $stable(vectorAddr)));

  assert_vector_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (vectorAddr[VEC_SH-1:0] == '0));

  assert_msr_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    entryValid |-> (!newMsr[B_EE] && !newMsr[B_PR] && !newMsr[B_IR] && !newMsr[B_DR]));

  assert_status_only_data_R12: assert property (@(posedge clk) disable iff (!rstN)
    (excAccept && excType != K_DATA) |=> $stable(dataStatus));
endmodule

bind excEntry excEntry_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .excValid  (excValid),
  .excType   (excType),
  .curMsr    (curMsr),
  .excAccept (excAccept),
  .entryValid(entryValid),
  .retAddr   (retAddr),
  .dataStatus(dataStatus),
  .newMsr    (newMsr),
  .vectorAddr(vectorAddr)
);

// File: tb/excEntry_tb.sv
module excEntry_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [3:0]  excType = '0;
  logic [2:0]  excCause = '0;
  logic [31:0] curMsr = '0;
  logic [31:0] nextPc = '0;
  logic [31:0] faultAddr = '0;
  logic        excAccept, entryValid;
  logic [31:0] retAddr, savedMsr, dataStatus, dataFaultAddr, newMsr, vectorAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic        eValid;
  logic [31:0] eRet, eSaved, eStat, eAddr, eMsr, eVec;

  always #5 clk = ~clk;

  excEntry u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit expAccept(input logic [3:0] t, input logic [31:0] m);
    if ((t == 4'd4 || t == 4'd8) && !m[15]) return 0;
    if (t == 4'd1 && !m[12]) return 0;
    return 1;
  endfunction

  function automatic bit expTake(input logic [3:0] t, input logic [2:0] c, input logic [31:0] m);
    if (t > 4'd10) return 0;
    if (t == 4'd6 && c[1:0] == 2'd0 && !m[11] && !m[8]) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] vecOf(input logic [3:0] t, input logic [31:0] m);
    logic [23:0] n;
    case (t)
      4'd9: n = 24'hC;
      4'd10: n = 24'hD;
      default: n = 24'(t) + 24'd1;
    endcase
    if (t == 4'd0 && m[6]) n = n + 24'hFFC00;
    return {n, 8'h00};
  endfunction

  function automatic logic [31:0] savedOf(input logic [3:0] t, input logic [2:0] c, input logic [31:0] m);
    logic [31:0] s;
    if (t != 4'd2 && t != 4'd3 && t != 4'd6) return m;
    s = m & 32'h0000FFFF;
    if (t == 4'd3) s |= (c[1:0] == 0) ? 32'h40000000 : (c[1:0] == 1) ? 32'h08000000 : 32'h10000000;
    if (t == 4'd6) s |= 32'h00010000 | (32'h00100000 >> c[1:0]);
    return s;
  endfunction

  function automatic logic [31:0] msrOf(input logic [3:0] t, input logic [31:0] m);
    logic [31:0] r;
    r = m & ~32'h0004EF33;
    r[0] = m[16];
    if (t == 4'd1) r[12] = 1'b0;
    return r;
  endfunction

  function automatic logic [31:0] statOf(input logic [2:0] c);
    logic [31:0] s;
    case (c[1:0])
      2'd0: s = 32'h40000000;
      2'd1: s = 32'h08000000;
      2'd2: s = 32'h80000000;
      default: s = 32'h84000000;
    endcase
    if (c[2]) s |= 32'h02000000;
    return s;
  endfunction

  task automatic compareAll(input string tag);
    chk({tag, " R11 entryValid"}, 32'(entryValid), 32'(eValid));
    chk({tag, " R5 retAddr"}, retAddr, eRet);
    chk({tag, " R3 R4 savedMsr"}, savedMsr, eSaved);
    chk({tag, " R2 dataStatus"}, dataStatus, eStat);
    chk({tag, " R12 dataFaultAddr"}, dataFaultAddr, eAddr);
    chk({tag, " R6 newMsr"}, newMsr, eMsr);
    chk({tag, " R7 vectorAddr"}, vectorAddr, eVec);
  endtask

  task automatic apply(input string tag, input logic v, input logic [3:0] t, input logic [2:0] c,
                       input logic [31:0] m, input logic [31:0] pc, input logic [31:0] fa);
    bit acc, tk;
    excValid = v; excType = t; excCause = c; curMsr = m; nextPc = pc; faultAddr = fa;
    acc = v && expAccept(t, m);
    tk = acc && expTake(t, c, m);
    #1;
    chk({tag, " R8 R10 R9 excAccept"}, 32'(excAccept), 32'(acc));
    @(posedge clk);
    eValid = tk;
    if (tk) begin
      eRet = (t == 4'd5 || t == 4'd6 || t == 4'd7) ? pc - 32'd4 : pc;
      eSaved = savedOf(t, c, m);
      eMsr = msrOf(t, m);
      eVec = vecOf(t, m);
      if (t == 4'd2) eStat = statOf(c);
      if (t == 4'd2 || t == 4'd5) eAddr = fa;
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    eValid = 0; eRet = 0; eSaved = 0; eStat = 0; eAddr = 0; eMsr = 0; eVec = 0;
    repeat (3) @(negedge clk);
    compareAll("reset R1");
    rstN = 1'b1;
    // prefix reset and plain reset
    apply("reset-prefix R7", 1, 4'd0, 3'd0, 32'h0001_0040, 32'h0000_1000, 32'h0);
    apply("reset-plain R7", 1, 4'd0, 3'd0, 32'h0000_0000, 32'h0000_2000, 32'h0);
    // store into direct-store area
    apply("data-direct-store R2", 1, 4'd2, 3'd7, 32'hFFFF_FFFF, 32'h0000_3000, 32'hDEAD_BEEF);
    // deferred external with busy outputs
    apply("ext-deferred R8", 1, 4'd4, 3'd0, 32'hFFFF_7FFF, 32'h1234_5678, 32'h1);
    apply("decr-deferred R8", 1, 4'd8, 3'd0, 32'h0000_0000, 32'h1234_5678, 32'h1);
    apply("ext-taken R8", 1, 4'd4, 3'd0, 32'h0000_8000, 32'h0000_4000, 32'h1);
    // machine check gated then taken
    apply("mchk-blocked R10", 1, 4'd1, 3'd0, 32'h0000_EFFF, 32'h0000_5000, 32'h0);
    apply("mchk-taken R10", 1, 4'd1, 3'd0, 32'h0000_1000, 32'h0000_6000, 32'h0);
    // FP program discarded, then enabled
    apply("fp-discard R9", 1, 4'd6, 3'd0, 32'hFFFF_F6FF, 32'h0000_7000, 32'h0);
    apply("fp-enabled R4", 1, 4'd6, 3'd0, 32'h0000_0800, 32'h0000_7000, 32'h0);
    apply("reserved R9", 1, 4'd13, 3'd1, 32'hFFFF_FFFF, 32'h0000_8000, 32'h5);
    apply("align R12", 1, 4'd5, 3'd0, 32'h0000_0000, 32'h0000_9000, 32'hCAFE_0001);
    apply("isi R3", 1, 4'd3, 3'd2, 32'hFFFF_FFFF, 32'h0000_A000, 32'h7);
    apply("idle R11", 0, 4'd2, 3'd0, 32'h0, 32'h0, 32'h0);
    for (int i = 0; i < 400; i++) begin
      logic [3:0] t;
      t = 4'($urandom_range(0, 12));
      apply("random", ($urandom_range(0, 7) != 0), t, 3'($urandom),
            $urandom, $urandom & 32'hFFFF_FFFC, $urandom);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule